// File: doc/BRIEF.md
# 32-Pin Function-Select Port Controller

This block owns one port of 32 pins. Each pin either works as a plain general-purpose pin or is handed to one of three peripheral functions. As a plain pin it is driven from an output data latch and a direction bit. As a function pin its output value and its output enable come straight from the chosen peripheral. Each function also has a per-pin input lane. That lane carries the pad level when the pin selects the function and a fixed idle level when it does not.

Software reaches the block through a simple write strobe and a read strobe on a small register space. The space holds two selection words, a direction word and a data word. Three further write ports, for set, clear and toggle masks, change the data latch bit by bit. Clearing one pin therefore needs no read-modify-write that could race with another owner of the port. A change to a selection word is applied to the pins only after a two-cycle commit pipeline. The word reads back its new value at once.

Top module: `gpmx_top`

## Requirements
- R1: After reset every selection field is 00, every direction bit is 0 and the data latch is 0, so pad_oe and pad_out are all zero and every fn_in lane shows its idle value.
- R2: Pin n takes its 2-bit selection from bits [2n+1:2n] of the low selection word (address 0) for n < 16, and from bits [2(n-16)+1:2(n-16)] of the high word (address 1) for n >= 16. Code 00 is plain GPIO; 01, 10 and 11 pick functions 1, 2 and 3, which sit on fn lanes 0, 1 and 2 (lane k occupies bits [32k+31:32k] of fn_out, fn_oe and fn_in).
- R3: A pin in plain mode drives pad_out from its data latch bit and pad_oe from its direction bit (1 = output, 0 = input).
- R4: A pin that selects function k drives pad_out and pad_oe from that lane's fn_out and fn_oe bits; the latch and direction bits have no effect on it.
- R5: fn_in bit n of lane k equals pad_in[n] while pin n selects function k+1, and otherwise the bit of the FN_IDLE parameter at the same position (default lane 0 all 0, lane 1 32'h0F0F_0F0F, lane 2 all 1).
- R6: A write to a selection word at clock edge E changes pin behaviour only from edge E+2 onward; a read of that word issued at E+1 already returns the new value.
- R7: On each edge the latch becomes ((base ^ T) | S) & ~C. Here base is wr_data on a data-word write (address 3), else the old latch. T, S and C are the toggle, set and clear masks, each zero when its strobe is low. Clear beats set, and set beats toggle; mask bits of 0 leave a bit unchanged.
- R8: A write to the data word (address 3) loads the latch; a read of address 3 returns pad_in as sampled at the read edge, not the latch.
- R9: A read strobe loads rd_data on that edge from address 0, 1, 2 or 3; addresses 4 to 7 read 0 and ignore writes; without a read strobe rd_data holds its value.
- R10: A write to address 2 loads the direction word, and a read of address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| set_we | input | 1 | Set-mask strobe |
| set_mask | input | 32 | Latch bits to drive high |
| clr_we | input | 1 | Clear-mask strobe |
| clr_mask | input | 32 | Latch bits to drive low |
| tgl_we | input | 1 | Toggle-mask strobe |
| tgl_mask | input | 32 | Latch bits to invert |
| pad_in | input | 32 | Pin input levels |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| fn_out | input | 96 | Peripheral output values, three lanes |
| fn_oe | input | 96 | Peripheral output enables, three lanes |
| fn_in | output | 96 | Peripheral input values, three lanes |

## Verification
The bench writes a selection word and watches the pins across the next two edges. A design that applied the change at once, or one cycle late, shows the peripheral value a cycle early or the latch a cycle too long. It drives set, clear and toggle onto the same bits, alone and together with a data-word write. An inverted priority then leaves bits high that must be low, or flips bits that set should have forced. It checks the fn_in lanes against the idle pattern on unselected pins, where a design that drove 0 everywhere fails on lanes 1 and 2. It also reads the data word while the latch and pad_in differ, which shows a design that returns the latch.

// File: rtl/gpmx_pkg.sv
package gpmx_pkg;

    localparam int ADDR_W   = 3;
    localparam int FN_LANES = 3;

    typedef enum logic [1:0] {
        SEL_GPIO = 2'd0,
        SEL_FN1  = 2'd1,
        SEL_FN2  = 2'd2,
        SEL_FN3  = 2'd3
    } pin_sel_e;

endpackage

// File: rtl/gpmx_regs.sv
module gpmx_regs
    import gpmx_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [NPINS-1:0]    wr_data,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    input  logic                set_we,
    input  logic [NPINS-1:0]    set_mask,
    input  logic                clr_we,
    input  logic [NPINS-1:0]    clr_mask,
    input  logic                tgl_we,
    input  logic [NPINS-1:0]    tgl_mask,
    input  logic [NPINS-1:0]    pad_in,
    output logic [NPINS-1:0]    rd_data,
    output logic [2*NPINS-1:0]  mux_cfg,
    output logic [NPINS-1:0]    dir_q,
    output logic [NPINS-1:0]    lat_q
);

    localparam int MUX_W     = 2 * NPINS;
    localparam int MUX_WORDS = MUX_W / NPINS;
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(MUX_WORDS);
    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(MUX_WORDS + 1);

    logic [MUX_W-1:0] mux_q;
    logic [NPINS-1:0] rd_q;
    logic [NPINS-1:0] lat_base, lat_nxt, set_eff, clr_eff, tgl_eff;
    logic [NPINS-1:0] rd_sel;

    // Atomic update: toggle first, then set, then clear (clear wins).
    always_comb begin
        lat_base = (wr_en && wr_addr == A_DAT) ? wr_data : lat_q;
        tgl_eff  = tgl_we ? tgl_mask : '0;
        set_eff  = set_we ? set_mask : '0;
        clr_eff  = clr_we ? clr_mask : '0;
        lat_nxt  = ((lat_base ^ tgl_eff) | set_eff) & ~clr_eff;
    end

    always_comb begin
        rd_sel = '0;
        for (int w = 0; w < MUX_WORDS; w++) begin
            if (rd_addr == ADDR_W'(w)) rd_sel = mux_q[w*NPINS +: NPINS];
        end
        if (rd_addr == A_DIR) rd_sel = dir_q;
        if (rd_addr == A_DAT) rd_sel = pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mux_q <= '0;
            dir_q <= '0;
            lat_q <= '0;
            rd_q  <= '0;
        end else begin
            for (int w = 0; w < MUX_WORDS; w++) begin
                if (wr_en && wr_addr == ADDR_W'(w)) mux_q[w*NPINS +: NPINS] <= wr_data;
            end
            if (wr_en && wr_addr == A_DIR) dir_q <= wr_data;
            lat_q <= lat_nxt;
            if (rd_en) rd_q <= rd_sel;
        end
    end

    assign mux_cfg = mux_q;
    assign rd_data = rd_q;

endmodule

// File: rtl/gpmx_commit.sv
module gpmx_commit #(
    parameter int W     = 64,
    parameter int DELAY = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] cfg_act
);

    logic [W-1:0] pipe_q [DELAY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DELAY; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= cfg_in;
            for (int i = 1; i < DELAY; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign cfg_act = pipe_q[DELAY-1];

endmodule

// File: rtl/gpmx_route.sv
module gpmx_route
    import gpmx_pkg::*;
#(
    parameter int NPINS = 32,
    parameter logic [FN_LANES*NPINS-1:0] FN_IDLE = '0
) (
    input  logic [2*NPINS-1:0]         sel_act,
    input  logic [NPINS-1:0]           latch,
    input  logic [NPINS-1:0]           dir,
    input  logic [NPINS-1:0]           pad_in,
    input  logic [FN_LANES*NPINS-1:0]  fn_out,
    input  logic [FN_LANES*NPINS-1:0]  fn_oe,
    output logic [NPINS-1:0]           pad_out,
    output logic [NPINS-1:0]           pad_oe,
    output logic [FN_LANES*NPINS-1:0]  fn_in
);

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        pin_sel_e sel;
        logic     po, oe;

        assign sel = pin_sel_e'(sel_act[2*n +: 2]);

        always_comb begin
            unique case (sel)
                SEL_GPIO: begin po = latch[n];                oe = dir[n];                end
                SEL_FN1:  begin po = fn_out[0*NPINS + n];     oe = fn_oe[0*NPINS + n];     end
                SEL_FN2:  begin po = fn_out[1*NPINS + n];     oe = fn_oe[1*NPINS + n];     end
                SEL_FN3:  begin po = fn_out[2*NPINS + n];     oe = fn_oe[2*NPINS + n];     end
            endcase
        end

        assign pad_out[n] = po;
        assign pad_oe[n]  = oe;

        for (genvar k = 0; k < FN_LANES; k++) begin : g_lane
            assign fn_in[k*NPINS + n] = (sel == pin_sel_e'(2'(k + 1))) ? pad_in[n]
                                                                      : FN_IDLE[k*NPINS + n];
        end
    end

endmodule

// File: rtl/gpmx_top.sv
module gpmx_top
    import gpmx_pkg::*;
#(
    parameter int NPINS = 32,
    parameter logic [FN_LANES*NPINS-1:0] FN_IDLE = {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000},
    parameter int COMMIT_DELAY = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [NPINS-1:0]            wr_data,
    input  logic                        rd_en,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [NPINS-1:0]            rd_data,
    input  logic                        set_we,
    input  logic [NPINS-1:0]            set_mask,
    input  logic                        clr_we,
    input  logic [NPINS-1:0]            clr_mask,
    input  logic                        tgl_we,
    input  logic [NPINS-1:0]            tgl_mask,
    input  logic [NPINS-1:0]            pad_in,
    output logic [NPINS-1:0]            pad_out,
    output logic [NPINS-1:0]            pad_oe,
    input  logic [FN_LANES*NPINS-1:0]   fn_out,
    input  logic [FN_LANES*NPINS-1:0]   fn_oe,
    output logic [FN_LANES*NPINS-1:0]   fn_in
);

    localparam int SEL_W = 2 * NPINS;

    logic [SEL_W-1:0] mux_cfg;
    logic [SEL_W-1:0] sel_act;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] lat_q;

    gpmx_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .set_we   (set_we),
        .set_mask (set_mask),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .tgl_we   (tgl_we),
        .tgl_mask (tgl_mask),
        .pad_in   (pad_in),
        .rd_data  (rd_data),
        .mux_cfg  (mux_cfg),
        .dir_q    (dir_q),
        .lat_q    (lat_q)
    );

    gpmx_commit #(.W(SEL_W), .DELAY(COMMIT_DELAY)) u_commit (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_in  (mux_cfg),
        .cfg_act (sel_act)
    );

    gpmx_route #(.NPINS(NPINS), .FN_IDLE(FN_IDLE)) u_route (
        .sel_act (sel_act),
        .latch   (lat_q),
        .dir     (dir_q),
        .pad_in  (pad_in),
        .fn_out  (fn_out),
        .fn_oe   (fn_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .fn_in   (fn_in)
    );

endmodule

// File: rtl/gpmx_chk.sv
module gpmx_chk
    import gpmx_pkg::*;
#(
    parameter int NPINS = 32,
    parameter logic [FN_LANES*NPINS-1:0] FN_IDLE = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic                        set_we,
    input  logic [NPINS-1:0]            set_mask,
    input  logic                        clr_we,
    input  logic [NPINS-1:0]            clr_mask,
    input  logic                        tgl_we,
    input  logic [2*NPINS-1:0]          mux_cfg,
    input  logic [2*NPINS-1:0]          sel_act,
    input  logic [NPINS-1:0]            latch,
    input  logic [NPINS-1:0]            dir,
    input  logic [NPINS-1:0]            pad_in,
    input  logic [NPINS-1:0]            pad_out,
    input  logic [NPINS-1:0]            pad_oe,
    input  logic [FN_LANES*NPINS-1:0]   fn_out,
    input  logic [FN_LANES*NPINS-1:0]   fn_oe,
    input  logic [FN_LANES*NPINS-1:0]   fn_in
);

    localparam logic [ADDR_W-1:0] A_DAT = ADDR_W'(3);

    logic [NPINS-1:0] clr_eff, set_eff;
    logic             quiet;

    assign clr_eff = clr_we ? clr_mask : '0;
    assign set_eff = (set_we ? set_mask : '0) & ~clr_eff;
    assign quiet   = !(wr_en && wr_addr == A_DAT) && !set_we && !clr_we && !tgl_we;

    // R1: state right after reset release
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mux_cfg == '0 && latch == '0 && dir == '0 && pad_oe == '0));

    // R6: pins follow the selection words two edges late
    a_r6_commit_delay: assert property (@(posedge clk) disable iff (!rst_n)
        sel_act == $past(mux_cfg, 2));

    // R7: cleared bits are low after the edge
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((latch & $past(clr_mask)) == '0));

    // R7: set bits not also cleared are high after the edge
    a_r7_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((latch & $past(set_eff)) == $past(set_eff)));

    // R7: no strobe, no change
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(latch));

    for (genvar n = 0; n < NPINS; n++) begin : g_pin
        a_r3_gpio_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_act[2*n +: 2] == 2'b00) |-> (pad_out[n] == latch[n] && pad_oe[n] == dir[n]));
        for (genvar k = 0; k < FN_LANES; k++) begin : g_lane
            a_r4_fn_drive: assert property (@(posedge clk) disable iff (!rst_n)
                (sel_act[2*n +: 2] == 2'(k + 1)) |->
                (pad_out[n] == fn_out[k*NPINS + n] && pad_oe[n] == fn_oe[k*NPINS + n]));
            a_r5_fn_input: assert property (@(posedge clk) disable iff (!rst_n)
                fn_in[k*NPINS + n] == ((sel_act[2*n +: 2] == 2'(k + 1)) ? pad_in[n]
                                                                        : FN_IDLE[k*NPINS + n]));
        end
    end

endmodule

bind gpmx_top gpmx_chk #(.NPINS(NPINS), .FN_IDLE(FN_IDLE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .set_we   (set_we),
    .set_mask (set_mask),
    .clr_we   (clr_we),
    .clr_mask (clr_mask),
    .tgl_we   (tgl_we),
    .mux_cfg  (mux_cfg),
    .sel_act  (sel_act),
    .latch    (lat_q),
    .dir      (dir_q),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .fn_out   (fn_out),
    .fn_oe    (fn_oe),
    .fn_in    (fn_in)
);

// File: tb/sim_gpmx_top.sv
`timescale 1ns/1ps
module sim_gpmx_top;

    localparam int N = 32;
    localparam logic [3*N-1:0] IDLE = {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h0000_0000};

    logic           clk, rst_n;
    logic           wr_en, rd_en, set_we, clr_we, tgl_we;
    logic [2:0]     wr_addr, rd_addr;
    logic [N-1:0]   wr_data, rd_data, set_mask, clr_mask, tgl_mask;
    logic [N-1:0]   pad_in, pad_out, pad_oe;
    logic [3*N-1:0] fn_out, fn_oe, fn_in;

    gpmx_top #(.NPINS(N), .FN_IDLE(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .set_we(set_we), .set_mask(set_mask), .clr_we(clr_we), .clr_mask(clr_mask),
        .tgl_we(tgl_we), .tgl_mask(tgl_mask), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .fn_out(fn_out), .fn_oe(fn_oe), .fn_in(fn_in)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Reference model state
    logic [2*N-1:0] m_mux, m_stg, m_act;
    logic [N-1:0]   m_dir, m_lat, m_rd;

    task automatic chk(input string tag, input logic [3*N-1:0] act, input logic [3*N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [N-1:0] read_model(input logic [2:0] a);
        case (a)
            3'd0:    return m_mux[N-1:0];
            3'd1:    return m_mux[2*N-1:N];
            3'd2:    return m_dir;
            3'd3:    return pad_in;
            default: return '0;
        endcase
    endfunction

    task automatic model_edge();
        logic [N-1:0] base;
        if (rd_en) m_rd = read_model(rd_addr);
        m_act = m_stg;
        m_stg = m_mux;
        base  = m_lat;
        if (wr_en) begin
            case (wr_addr)
                3'd0:    m_mux[N-1:0]   = wr_data;
                3'd1:    m_mux[2*N-1:N] = wr_data;
                3'd2:    m_dir          = wr_data;
                3'd3:    base           = wr_data;
                default: ;
            endcase
        end
        m_lat = ((base ^ (tgl_we ? tgl_mask : '0)) | (set_we ? set_mask : '0))
                & ~(clr_we ? clr_mask : '0);
    endtask

    task automatic compare_all();
        logic [N-1:0]   po, oe;
        logic [3*N-1:0] fi;
        fi = IDLE;
        for (int n = 0; n < N; n++) begin
            int k;
            k = int'(m_act[2*n +: 2]) - 1;
            if (k < 0) begin
                po[n] = m_lat[n];
                oe[n] = m_dir[n];
            end else begin
                po[n] = fn_out[k*N + n];
                oe[n] = fn_oe[k*N + n];
                fi[k*N + n] = pad_in[n];
            end
        end
        chk("R3 R4 pad_out", {64'd0, pad_out}, {64'd0, po});
        chk("R3 R4 pad_oe",  {64'd0, pad_oe},  {64'd0, oe});
        chk("R5 fn_in", fn_in, fi);
        chk("R9 rd_data", {64'd0, rd_data}, {64'd0, m_rd});
    endtask

    task automatic quiet_inputs();
        wr_en = 0; rd_en = 0; set_we = 0; clr_we = 0; tgl_we = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
        quiet_inputs();
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [N-1:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
    endtask

    task automatic bus_rd(input logic [2:0] a);
        rd_en = 1; rd_addr = a;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 0;
        quiet_inputs();
        wr_addr = 0; rd_addr = 0; wr_data = 0;
        set_mask = 0; clr_mask = 0; tgl_mask = 0;
        pad_in = 32'hF0F0_1234;
        fn_out = {32'h1111_2222, 32'h0BAD_F00D, 32'hDEAD_BEEF};
        fn_oe  = {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000};
        m_mux = '0; m_stg = '0; m_act = '0; m_dir = '0; m_lat = '0; m_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state at the ports
        chk("R1 pad_oe",  {64'd0, pad_oe},  '0);
        chk("R1 pad_out", {64'd0, pad_out}, '0);
        chk("R1 fn_in idle", fn_in, IDLE);
        bus_rd(3'd0); tick();
        chk("R1 mux low reads 0", {64'd0, rd_data}, '0);

        // R10 / R8: direction and data word
        bus_wr(3'd2, 32'hFFFF_FFFF); tick();
        bus_wr(3'd3, 32'h1234_5678); bus_rd(3'd2); tick();
        chk("R10 dir readback", {64'd0, rd_data}, {64'd0, 32'hFFFF_FFFF});
        chk("R8 latch drives pad_out", {64'd0, pad_out}, {64'd0, 32'h1234_5678});
        bus_rd(3'd3); tick();
        chk("R8 data read returns pad_in", {64'd0, rd_data}, {64'd0, 32'hF0F0_1234});

        // R6 / R2: low word to function 1, two-edge delay
        bus_wr(3'd0, 32'h5555_5555); tick();
        chk("R6 edge0 unchanged", {64'd0, pad_out}, {64'd0, 32'h1234_5678});
        bus_rd(3'd0); tick();
        chk("R6 edge1 unchanged", {64'd0, pad_out}, {64'd0, 32'h1234_5678});
        chk("R6 readback immediate", {64'd0, rd_data}, {64'd0, 32'h5555_5555});
        tick();
        chk("R2 R4 low pins fn1 out", {64'd0, pad_out}, {64'd0, 32'h1234_BEEF});
        chk("R4 low pins fn1 oe", {64'd0, pad_oe}, {64'd0, 32'hFFFF_0000});
        chk("R5 lane0 input", {64'd0, fn_in[N-1:0]}, {64'd0, 32'h0000_1234});

        // R2: high word to function 2
        bus_wr(3'd1, 32'hAAAA_AAAA); tick(); tick(); tick();
        chk("R2 high pins fn2 out", {64'd0, pad_out}, {64'd0, 32'h0BAD_BEEF});
        chk("R5 lane1 input", {64'd0, fn_in[2*N-1:N]}, {64'd0, 32'hF0F0_0F0F});
        bus_wr(3'd0, 32'h0); tick();
        bus_wr(3'd1, 32'h0); tick(); tick(); tick();

        // R7: priority clear > set > toggle
        set_we = 1; set_mask = 32'h0000_000F;
        clr_we = 1; clr_mask = 32'h0000_0003;
        tgl_we = 1; tgl_mask = 32'h0000_0033;
        tick();
        chk("R7 all three strobes", {64'd0, pad_out}, {64'd0, 32'h1234_564C});
        tgl_we = 1; tgl_mask = 32'hFFFF_0000; tick();
        chk("R7 toggle only", {64'd0, pad_out}, {64'd0, 32'hEDCB_564C});
        set_we = 1; set_mask = 32'h0000_00F0; tgl_we = 1; tgl_mask = 32'h0000_00F0; tick();
        chk("R7 set beats toggle", {64'd0, pad_out}, {64'd0, 32'hEDCB_56FC});
        bus_wr(3'd3, 32'hFFFF_FFFF); clr_we = 1; clr_mask = 32'h0000_FFFF; tick();
        chk("R7 clear on top of data write", {64'd0, pad_out}, {64'd0, 32'hFFFF_0000});

        // R9: unused addresses
        bus_wr(3'd5, 32'hFFFF_FFFF); tick();
        bus_rd(3'd0); tick();
        chk("R9 ignored write keeps mux", {64'd0, rd_data}, '0);
        chk("R9 ignored write keeps latch", {64'd0, pad_out}, {64'd0, 32'hFFFF_0000});
        bus_rd(3'd6); tick();
        chk("R9 unused address reads 0", {64'd0, rd_data}, '0);
        bus_rd(3'd2); tick(); tick();
        chk("R9 rd_data holds", {64'd0, rd_data}, {64'd0, 32'hFFFF_FFFF});

        // Random phase
        for (int i = 0; i < 3000; i++) begin
            pad_in = $urandom;
            fn_out = {$urandom, $urandom, $urandom};
            fn_oe  = {$urandom, $urandom, $urandom};
            wr_en  = ($urandom % 3) == 0;
            wr_addr = 3'($urandom % 8);
            wr_data = $urandom;
            rd_en  = ($urandom % 2) == 0;
            rd_addr = 3'($urandom % 8);
            set_we = ($urandom % 3) == 0; set_mask = $urandom;
            clr_we = ($urandom % 3) == 0; clr_mask = $urandom;
            tgl_we = ($urandom % 3) == 0; tgl_mask = $urandom;
            tick();
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule